// File: doc/BRIEF.md
# Interrupt and Counter Control Register

This block is a control-register slice inside a framed serial transceiver. A host writes one control byte through a simple write strobe. The byte holds four fields: a master enable for the two serial output drivers, a suspend switch for the interrupt pin, an acknowledge bit, and a clear for a bank of status counters. The block turns these fields into the driver enables, the interrupt pin and its drive enable, and a counter-clear level.

Internal detectors raise interrupt events on a vector of source lines. Any source line that is high in a clock cycle while suspend is off latches a pending interrupt. The pending interrupt drives the active-low IRQ pin. The host clears the pending interrupt by flipping the acknowledge bit in either direction. A write that leaves the acknowledge bit unchanged does not clear anything. While suspend is on, the IRQ pin is floated and source events are dropped.

Top module: `icc_ctrl`

## Requirements
- R1: After reset, the control fields are all zero and nothing is pending. So irq_n=1, irq_oe=1, irq_pending=0, cnt_clr=0 and strm_oe is all zero.
- R2: A cycle with wr_en high loads the control byte, and the new fields act from the next cycle. The field positions are: bit 0 counter clear, bit 1 acknowledge, bit 2 suspend, bit 3 output master enable. Bits 7:4 are ignored.
- R3: cnt_clr follows the stored counter-clear bit. It stays high for as long as that bit stays one, and it changes only after a write.
- R4: While the stored master enable is zero, every bit of strm_oe is zero, whatever strm_en holds.
- R5: While the stored master enable is one, strm_oe[i] follows strm_en[i] in the same cycle, for each stream independently.
- R6: A cycle in which any irq_src bit is high and suspend is zero sets irq_pending from the next cycle.
- R7: While the stored suspend bit is one, irq_oe is zero and source events leave irq_pending unchanged.
- R8: A write whose acknowledge bit differs from the stored one (0 to 1 or 1 to 0) clears irq_pending from the next cycle. A write with the same acknowledge value does not clear it.
- R9: A source event in the same cycle as an acknowledge toggle takes priority, so irq_pending is one afterwards.
- R10: irq_n is the inverse of irq_pending, so it is low exactly while an interrupt is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | DATA_W | Control byte being written |
| irq_src | input | NUM_SRC | Interrupt source event lines |
| strm_en | input | NUM_STRM | Per-stream driver enable bits from another register |
| irq_n | output | 1 | Active-low interrupt request value |
| irq_oe | output | 1 | Drive enable for the IRQ pin (0 = high impedance) |
| irq_pending | output | 1 | Pending-interrupt state |
| cnt_clr | output | 1 | Clear-and-hold level for the status counters |
| strm_oe | output | NUM_STRM | Driver enables for the serial output streams |

## Verification
On every cycle, the assertions check these rules:
- an unsuspended event always leaves a pending interrupt (R6, R9);
- a suspended, idle pin stays idle (R7);
- a non-colliding acknowledge toggle clears the pending state (R8);
- a stream is never enabled without its own enable bit (R5);
- the counter clear moves only after a write (R3).

Some behaviour only the bench scenarios can show. This covers:
- the exact field positions (R2);
- the absence of a clear when the acknowledge value is rewritten unchanged (R8);
- events dropped while suspended (R7);
- the master gate overriding all stream enables (R4);
- the reset values seen again after a mid-run reset (R1).

// File: rtl/icc_pkg.sv
package icc_pkg;
    localparam int CTRL_W   = 8;
    localparam int CLR_BIT  = 0;
    localparam int ACK_BIT  = 1;
    localparam int SUSP_BIT = 2;
    localparam int MOE_BIT  = 3;

    typedef struct packed {
        logic moe;
        logic susp;
        logic ack;
        logic clr;
    } ctrl_t;
endpackage

// File: rtl/icc_ctrl_reg.sv
module icc_ctrl_reg
    import icc_pkg::*;
#(
    parameter int DATA_W = CTRL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic              ack_flip
);
    typedef struct packed {
        ctrl_t c;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        ack_flip = 1'b0;
        if (wr_en) begin
            ack_flip    = wr_data[ACK_BIT] != st_q.c.ack;
            st_d.c.clr  = wr_data[CLR_BIT];
            st_d.c.ack  = wr_data[ACK_BIT];
            st_d.c.susp = wr_data[SUSP_BIT];
            st_d.c.moe  = wr_data[MOE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl = st_q.c;
endmodule

// File: rtl/icc_irq_pend.sv
module icc_irq_pend #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src,
    input  logic               suspend,
    input  logic               ack_flip,
    output logic               pending
);
    typedef struct packed {
        logic pend;
    } pend_state_t;

    pend_state_t st_d, st_q;
    logic        evt;

    always_comb begin
        st_d = st_q;
        evt  = !suspend && (|src);
        if (evt)           st_d.pend = 1'b1;
        else if (ack_flip) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending = st_q.pend;
endmodule

// File: rtl/icc_oe_gate.sv
module icc_oe_gate #(
    parameter int NUM_STRM = 2
) (
    input  logic                master,
    input  logic [NUM_STRM-1:0] strm_en,
    output logic [NUM_STRM-1:0] strm_oe
);
    for (genvar i = 0; i < NUM_STRM; i++) begin : g_strm
        assign strm_oe[i] = master & strm_en[i];
    end
endmodule

// File: rtl/icc_ctrl.sv
module icc_ctrl
    import icc_pkg::*;
#(
    parameter int DATA_W   = CTRL_W,
    parameter int NUM_SRC  = 8,
    parameter int NUM_STRM = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [NUM_SRC-1:0]  irq_src,
    input  logic [NUM_STRM-1:0] strm_en,
    output logic                irq_n,
    output logic                irq_oe,
    output logic                irq_pending,
    output logic                cnt_clr,
    output logic [NUM_STRM-1:0] strm_oe
);
    ctrl_t ctrl;
    logic  ack_flip;

    icc_ctrl_reg #(.DATA_W(DATA_W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ctrl     (ctrl),
        .ack_flip (ack_flip)
    );

    icc_irq_pend #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (irq_src),
        .suspend  (ctrl.susp),
        .ack_flip (ack_flip),
        .pending  (irq_pending)
    );

    icc_oe_gate #(.NUM_STRM(NUM_STRM)) u_gate (
        .master  (ctrl.moe),
        .strm_en (strm_en),
        .strm_oe (strm_oe)
    );

    assign irq_n   = ~irq_pending;
    assign irq_oe  = ~ctrl.susp;
    assign cnt_clr = ctrl.clr;
endmodule

// File: rtl/icc_ctrl_chk.sv
module icc_ctrl_chk
    import icc_pkg::*;
#(
    parameter int DATA_W   = CTRL_W,
    parameter int NUM_SRC  = 8,
    parameter int NUM_STRM = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [DATA_W-1:0]   wr_data,
    input logic [NUM_SRC-1:0]  irq_src,
    input logic [NUM_STRM-1:0] strm_en,
    input logic                irq_n,
    input logic                irq_oe,
    input logic                irq_pending,
    input logic                cnt_clr,
    input logic [NUM_STRM-1:0] strm_oe
);
    logic ack_shadow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ack_shadow <= 1'b0;
        else if (wr_en) ack_shadow <= wr_data[ACK_BIT];
    end

    // R6 R9
    event_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_oe && (|irq_src)) |=> irq_pending);

    // R7
    suspend_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_oe && !irq_pending) |=> !irq_pending);

    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_data[ACK_BIT] != ack_shadow) && !(irq_oe && (|irq_src)))
        |=> !irq_pending);

    // R5
    strm_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strm_oe & ~strm_en) == '0);

    // R3
    clr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cnt_clr));

    // R6
    pend_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pending) |-> $past(irq_oe && (|irq_src)));

    // R10
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n != irq_pending);
endmodule

bind icc_ctrl icc_ctrl_chk #(
    .DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .NUM_STRM(NUM_STRM)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .irq_src     (irq_src),
    .strm_en     (strm_en),
    .irq_n       (irq_n),
    .irq_oe      (irq_oe),
    .irq_pending (irq_pending),
    .cnt_clr     (cnt_clr),
    .strm_oe     (strm_oe)
);

// File: tb/icc_ctrl_test.sv
module icc_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] irq_src = '0;
    logic [1:0] strm_en = '0;
    logic       irq_n, irq_oe, irq_pending, cnt_clr;
    logic [1:0] strm_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    icc_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .irq_src(irq_src), .strm_en(strm_en), .irq_n(irq_n), .irq_oe(irq_oe),
        .irq_pending(irq_pending), .cnt_clr(cnt_clr), .strm_oe(strm_oe)
    );

    typedef struct packed {
        logic       wr;
        logic [7:0] data;
        logic [7:0] src;
        logic [1:0] en;
        logic       e_n;
        logic       e_oe;
        logic       e_p;
        logic       e_clr;
        logic [1:0] e_soe;
    } vec_t;

    // data bits: 0 clear, 1 ack, 2 suspend, 3 master enable
    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 8'h08, 8'h00, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 2'b11}, // R2 R5
        '{1'b0, 8'h00, 8'h01, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 2'b01}, // R6 R10
        '{1'b1, 8'hFA, 8'h00, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 2'b10}, // R8 0->1, R2 upper bits
        '{1'b0, 8'h00, 8'h80, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 2'b10}, // R6
        '{1'b1, 8'h0A, 8'h00, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 2'b10}, // R8 same ack
        '{1'b1, 8'h08, 8'h00, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00}, // R8 1->0
        '{1'b1, 8'h0A, 8'h04, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 2'b11}, // R9
        '{1'b1, 8'h0E, 8'h00, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 2'b11}, // R7 float
        '{1'b1, 8'h0C, 8'h00, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11}, // R8 under suspend
        '{1'b0, 8'h00, 8'hFF, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11}, // R7 ignored
        '{1'b1, 8'h09, 8'h00, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 2'b01}, // R3 set
        '{1'b0, 8'h00, 8'h00, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 2'b01}, // R3 held
        '{1'b1, 8'h01, 8'h00, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 2'b00}, // R4
        '{1'b0, 8'h00, 8'h00, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 2'b00}, // R4
        '{1'b1, 8'h00, 8'h00, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00}  // R3 release
    };

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_reset(input string tag);
        chk(tag, "irq_n", {7'd0, irq_n}, 8'd1);
        chk(tag, "irq_oe", {7'd0, irq_oe}, 8'd1);
        chk(tag, "irq_pending", {7'd0, irq_pending}, 8'd0);
        chk(tag, "cnt_clr", {7'd0, cnt_clr}, 8'd0);
        chk(tag, "strm_oe", {6'd0, strm_oe}, 8'd0);
    endtask

    task automatic step(input logic w, input logic [7:0] d,
                        input logic [7:0] s, input logic [1:0] e);
        wr_en = w; wr_data = d; irq_src = s; strm_en = e;
        @(negedge clk);
        wr_en = 1'b0; irq_src = '0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        strm_en = 2'b11;
        repeat (2) @(negedge clk);
        chk_reset("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_reset("R1");

        for (int i = 0; i < NV; i++) begin
            step(TBL[i].wr, TBL[i].data, TBL[i].src, TBL[i].en);
            strm_en = TBL[i].en;
            chk("R10", "irq_n", {7'd0, irq_n}, {7'd0, TBL[i].e_n});
            chk("R7", "irq_oe", {7'd0, irq_oe}, {7'd0, TBL[i].e_oe});
            chk("R6/R8", "irq_pending", {7'd0, irq_pending}, {7'd0, TBL[i].e_p});
            chk("R3", "cnt_clr", {7'd0, cnt_clr}, {7'd0, TBL[i].e_clr});
            chk("R4/R5", "strm_oe", {6'd0, strm_oe}, {6'd0, TBL[i].e_soe});
        end

        // R5: same-cycle follow of strm_en with master on
        step(1'b1, 8'h08, 8'h00, 2'b00);
        strm_en = 2'b01; #1;
        chk("R5", "strm_oe", {6'd0, strm_oe}, 8'h01);
        strm_en = 2'b10; #1;
        chk("R5", "strm_oe", {6'd0, strm_oe}, 8'h02);

        // R7: suspend written in the same cycle as an event; old suspend=0 applies
        step(1'b1, 8'h0C, 8'h10, 2'b10);
        chk("R7", "irq_pending", {7'd0, irq_pending}, 8'd1);
        chk("R7", "irq_oe", {7'd0, irq_oe}, 8'd0);

        // R1: reset mid-run with pending, clear, and master enable set
        step(1'b1, 8'h09, 8'h00, 2'b11);
        rst_n = 1'b0;
        #2;
        chk_reset("R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_reset("R1");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule